// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the processor-facing register port of an eight-line interrupt controller. It has a byte-wide data path and a single address bit. It turns byte writes into configuration state: the vector base, the line mask, and the nesting, end-of-interrupt and masking mode flags. It also turns reads into register data taken from the request latch and the priority resolver, which sit beside it. Commands that act on priority, such as end-of-interrupt and rotation, are not decoded here. They are passed on to the priority block as a one-cycle strobe that carries the written byte.

Configuration begins with a start word on the control address. A fixed run of words on the data address follows: the vector base first, then a cascade word that is accepted and discarded, then an optional mode word. The start word itself says whether the mode word will come. A poll command arms a one-shot read. The next read of either address returns the number of the winning line instead of a register. It also tells the request latch and the in-service tracker to drop that line.

All outputs are registered. A write takes effect on the edge that samples it. Read data, strobes and the poll clear all appear in the cycle that follows the sampled strobe.

Top module: `irq_regif`

## Requirements
- R1: A write to address 0 with data bit 4 set is a start word. On the next cycle `init_stb_o` pulses high for one cycle, and the mask, special-mask flag and read-select flag are all zero. Nesting and auto-EOI modes are cleared unless data bit 0 (the fourth-word flag) is set, in which case they keep their values.
- R2: The first address-1 write after a start word sets `vec_base_o` to data bits 7:3 followed by three zero bits.
- R3: The second address-1 write after a start word (the cascade word) changes no output. If the fourth-word flag was clear, configuration ends there and the next address-1 write loads the mask. If it was set, one more word is expected first.
- R4: In the fourth word, data bit 4 sets `fully_nested_o` and data bit 1 sets `auto_eoi_o`. The next address-1 write after it loads the mask.
- R5: Outside the configuration sequence, an address-1 write loads the whole byte into `mask_o`.
- R6: An address-0 write with bit 4 clear and bit 3 set is a mode command. If bit 1 is set, bit 0 selects the in-service register (1) or the pending register (0) for address-0 reads. If bit 1 is clear, the selection is unchanged.
- R7: In a mode command, bit 6 set loads bit 5 into `spec_mask_o`. If bit 6 is clear, the flag is unchanged.
- R8: An address-0 write with bits 4 and 3 both clear pulses `ocw_stb_o` for one cycle on the next cycle, with `ocw_data_o` equal to the written byte. No other write pulses it.
- R9: When no poll is armed, a read returns on the next cycle either the in-service or the pending register (address 0, chosen by the select flag) or the mask (address 1).
- R10: A mode command with bit 2 set arms poll. The next read, at either address, returns the resolver's winning line number. It also pulses `poll_clr_o` with `poll_line_o` equal to that line, and disarms poll, so the read after it is a normal read.
- R11: A poll read when the resolver reports no winner returns 7 and leaves `poll_clr_o` low.
- R12: Synchronous active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 1 | Register address bit |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| pend_i | input | 8 | Pending register from the request latch |
| insvc_i | input | 8 | In-service register |
| win_valid_i | input | 1 | Resolver has a winning line |
| win_line_i | input | 3 | Winning line number |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| mask_o | output | 8 | Line mask |
| fully_nested_o | output | 1 | Special fully nested mode |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt mode |
| spec_mask_o | output | 1 | Special mask mode |
| init_stb_o | output | 1 | Controller reset pulse to the priority block (clears rotation base) |
| ocw_stb_o | output | 1 | Operation command strobe |
| ocw_data_o | output | 8 | Operation command byte |
| poll_clr_o | output | 1 | Poll acknowledge: drop pending and in-service for a line |
| poll_line_o | output | 3 | Line cleared by the poll acknowledge |
| rd_data_o | output | 8 | Read data |

## Verification
The hardest state to reach is the middle of the configuration sequence. The sequencer position is not visible at the ports, and the cascade word changes nothing there. The stimulus therefore runs complete sequences with and without the fourth word. It sends a recognisable byte after the last expected word and checks whether that byte lands in the mask or in the mode flags. The one-shot poll is checked with two reads in a row, one with a resolver winner and one without, to show both the acknowledge and the disarm.

// File: rtl/irq_regif_pkg.sv
// Package: shared types and bit positions for the interrupt register port.
// Assumes byte-wide data; the bit positions below are the command encoding.
package irq_regif_pkg;

    typedef enum logic [1:0] {
        STEP_RUN  = 2'd0,
        STEP_BASE = 2'd1,
        STEP_CASC = 2'd2,
        STEP_MODE = 2'd3
    } init_step_e;

    localparam int BIT_START   = 4;   // start word marker (address 0)
    localparam int BIT_MODECMD = 3;   // mode command marker (address 0, start clear)
    localparam int BIT_WANT4   = 0;   // start word: fourth word follows
    localparam int BIT_POLL    = 2;   // mode command: arm poll
    localparam int BIT_RSEL_EN = 1;   // mode command: read select valid
    localparam int BIT_RSEL    = 0;   // mode command: read in-service
    localparam int BIT_SMM_EN  = 6;   // mode command: special mask valid
    localparam int BIT_SMM     = 5;   // mode command: special mask value
    localparam int BIT_NESTED  = 4;   // fourth word: fully nested
    localparam int BIT_AEOI    = 1;   // fourth word: automatic EOI
    localparam int BASE_LSB    = 3;   // vector base low boundary

endpackage

// File: rtl/irq_init_seq.sv
// Module: configuration word sequencer.
// Tracks the start / base / cascade / optional mode words and holds the
// vector base and the nesting and auto-EOI flags. Assumes writes are
// single-cycle strobes already split by address.
module irq_init_seq
    import irq_regif_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_cfg,
    input  logic [DATA_W-1:0] wr_data,
    output logic              init_start,
    output logic              run_mode,
    output logic [DATA_W-1:0] vec_base,
    output logic              fully_nested,
    output logic              auto_eoi
);

    localparam int BASE_W = DATA_W - BASE_LSB;

    init_step_e step_q;
    logic       want4_q;
    logic [BASE_W-1:0] base_q;
    logic       nested_q;
    logic       aeoi_q;

    assign init_start = wr_ctl && wr_data[BIT_START];
    assign run_mode   = (step_q == STEP_RUN);
    assign vec_base   = {base_q, {BASE_LSB{1'b0}}};
    assign fully_nested = nested_q;
    assign auto_eoi     = aeoi_q;

    // Step register and fourth-word flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= STEP_RUN;
            want4_q <= 1'b0;
        end else if (init_start) begin
            step_q  <= STEP_BASE;
            want4_q <= wr_data[BIT_WANT4];
        end else if (wr_cfg) begin
            case (step_q)
                STEP_BASE: step_q <= STEP_CASC;
                STEP_CASC: step_q <= want4_q ? STEP_MODE : STEP_RUN;
                STEP_MODE: step_q <= STEP_RUN;
                default:   step_q <= STEP_RUN;
            endcase
        end
    end

    // Vector base captured from the first data-address word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_cfg && !init_start && step_q == STEP_BASE) begin
            base_q <= wr_data[DATA_W-1:BASE_LSB];
        end
    end

    // Mode flags: cleared by a start word without a fourth word, set by it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nested_q <= 1'b0;
            aeoi_q   <= 1'b0;
        end else if (init_start) begin
            if (!wr_data[BIT_WANT4]) begin
                nested_q <= 1'b0;
                aeoi_q   <= 1'b0;
            end
        end else if (wr_cfg && step_q == STEP_MODE) begin
            nested_q <= wr_data[BIT_NESTED];
            aeoi_q   <= wr_data[BIT_AEOI];
        end
    end

endmodule

// File: rtl/irq_cmd_dec.sv
// Module: command decoder.
// Holds the mask, read select, special mask and poll arm; forwards
// operation commands. Assumes init_start and run_mode come from the
// sequencer in the same cycle as the write.
module irq_cmd_dec
    import irq_regif_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_cfg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              init_start,
    input  logic              run_mode,
    input  logic              poll_taken,
    output logic [DATA_W-1:0] mask,
    output logic              rd_isr_sel,
    output logic              spec_mask,
    output logic              poll_armed,
    output logic              init_stb,
    output logic              ocw_stb,
    output logic [DATA_W-1:0] ocw_data
);

    logic mode_cmd;
    logic op_cmd;

    assign mode_cmd = wr_ctl && !wr_data[BIT_START] && wr_data[BIT_MODECMD];
    assign op_cmd   = wr_ctl && !wr_data[BIT_START] && !wr_data[BIT_MODECMD];

    // Mask register: cleared by a start word, loaded in run mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (init_start) begin
            mask <= '0;
        end else if (wr_cfg && run_mode) begin
            mask <= wr_data;
        end
    end

    // Read select and special mask flags.
    always_ff @(posedge clk) begin
        if (!rst_n || init_start) begin
            rd_isr_sel <= 1'b0;
            spec_mask  <= 1'b0;
        end else if (mode_cmd) begin
            if (wr_data[BIT_RSEL_EN]) rd_isr_sel <= wr_data[BIT_RSEL];
            if (wr_data[BIT_SMM_EN])  spec_mask  <= wr_data[BIT_SMM];
        end
    end

    // One-shot poll arm: set by a mode command, dropped by a poll read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_armed <= 1'b0;
        end else if (mode_cmd && wr_data[BIT_POLL]) begin
            poll_armed <= 1'b1;
        end else if (poll_taken) begin
            poll_armed <= 1'b0;
        end
    end

    // Strobes toward the priority block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_stb <= 1'b0;
            ocw_stb  <= 1'b0;
            ocw_data <= '0;
        end else begin
            init_stb <= init_start;
            ocw_stb  <= op_cmd;
            if (op_cmd) ocw_data <= wr_data;
        end
    end

endmodule

// File: rtl/irq_rd_path.sv
// Module: read data path.
// Registers register reads and poll results; raises the poll acknowledge.
// Assumes the resolver inputs are stable in the cycle of the read strobe.
module irq_rd_path #(
    parameter int DATA_W    = 8,
    parameter int NUM_LINES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic                         addr,
    input  logic                         poll_armed,
    input  logic                         rd_isr_sel,
    input  logic [NUM_LINES-1:0]         pend,
    input  logic [NUM_LINES-1:0]         insvc,
    input  logic [DATA_W-1:0]            mask,
    input  logic                         win_valid,
    input  logic [$clog2(NUM_LINES)-1:0] win_line,
    output logic                         poll_taken,
    output logic                         poll_clr,
    output logic [$clog2(NUM_LINES)-1:0] poll_line,
    output logic [DATA_W-1:0]            rd_data
);

    localparam int LINE_W = $clog2(NUM_LINES);
    localparam logic [LINE_W-1:0] NO_WIN = LINE_W'(NUM_LINES - 1);

    logic [LINE_W-1:0] poll_val;
    logic [DATA_W-1:0] reg_val;

    assign poll_taken = rd_en && poll_armed;
    assign poll_val   = win_valid ? win_line : NO_WIN;

    // Plain register selection.
    always_comb begin
        if (addr)            reg_val = mask;
        else if (rd_isr_sel) reg_val = DATA_W'(insvc);
        else                 reg_val = DATA_W'(pend);
    end

    // Read data and poll acknowledge registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            poll_clr  <= 1'b0;
            poll_line <= '0;
        end else begin
            poll_clr <= poll_taken && win_valid;
            if (poll_taken && win_valid) poll_line <= win_line;
            if (poll_taken)              rd_data <= DATA_W'(poll_val);
            else if (rd_en)              rd_data <= reg_val;
        end
    end

endmodule

// File: rtl/irq_regif.sv
// Module: register port top for an eight-line interrupt controller.
// Splits writes by address and joins sequencer, decoder and read path.
// Assumes read and write strobes are one cycle wide and not concurrent.
module irq_regif #(
    parameter int DATA_W    = 8,
    parameter int NUM_LINES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         addr_i,
    input  logic                         wr_en_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    input  logic                         rd_en_i,
    input  logic [NUM_LINES-1:0]         pend_i,
    input  logic [NUM_LINES-1:0]         insvc_i,
    input  logic                         win_valid_i,
    input  logic [$clog2(NUM_LINES)-1:0] win_line_i,
    output logic [DATA_W-1:0]            vec_base_o,
    output logic [DATA_W-1:0]            mask_o,
    output logic                         fully_nested_o,
    output logic                         auto_eoi_o,
    output logic                         spec_mask_o,
    output logic                         init_stb_o,
    output logic                         ocw_stb_o,
    output logic [DATA_W-1:0]            ocw_data_o,
    output logic                         poll_clr_o,
    output logic [$clog2(NUM_LINES)-1:0] poll_line_o,
    output logic [DATA_W-1:0]            rd_data_o
);

    logic wr_ctl;
    logic wr_cfg;
    logic init_start;
    logic run_mode;
    logic rd_isr_sel;
    logic poll_armed;
    logic poll_taken;

    assign wr_ctl = wr_en_i && !addr_i;
    assign wr_cfg = wr_en_i && addr_i;

    irq_init_seq #(.DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ctl       (wr_ctl),
        .wr_cfg       (wr_cfg),
        .wr_data      (wr_data_i),
        .init_start   (init_start),
        .run_mode     (run_mode),
        .vec_base     (vec_base_o),
        .fully_nested (fully_nested_o),
        .auto_eoi     (auto_eoi_o)
    );

    irq_cmd_dec #(.DATA_W(DATA_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctl     (wr_ctl),
        .wr_cfg     (wr_cfg),
        .wr_data    (wr_data_i),
        .init_start (init_start),
        .run_mode   (run_mode),
        .poll_taken (poll_taken),
        .mask       (mask_o),
        .rd_isr_sel (rd_isr_sel),
        .spec_mask  (spec_mask_o),
        .poll_armed (poll_armed),
        .init_stb   (init_stb_o),
        .ocw_stb    (ocw_stb_o),
        .ocw_data   (ocw_data_o)
    );

    irq_rd_path #(.DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en_i),
        .addr       (addr_i),
        .poll_armed (poll_armed),
        .rd_isr_sel (rd_isr_sel),
        .pend       (pend_i),
        .insvc      (insvc_i),
        .mask       (mask_o),
        .win_valid  (win_valid_i),
        .win_line   (win_line_i),
        .poll_taken (poll_taken),
        .poll_clr   (poll_clr_o),
        .poll_line  (poll_line_o),
        .rd_data    (rd_data_o)
    );

endmodule

// File: rtl/irq_regif_chk.sv
// Module: property checker for irq_regif, attached by bind.
module irq_regif_chk #(
    parameter int DATA_W    = 8,
    parameter int NUM_LINES = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         addr_i,
    input logic                         wr_en_i,
    input logic [DATA_W-1:0]            wr_data_i,
    input logic                         rd_en_i,
    input logic                         win_valid_i,
    input logic [DATA_W-1:0]            vec_base_o,
    input logic [DATA_W-1:0]            mask_o,
    input logic                         fully_nested_o,
    input logic                         auto_eoi_o,
    input logic                         spec_mask_o,
    input logic                         init_stb_o,
    input logic                         ocw_stb_o,
    input logic                         poll_clr_o,
    input logic [$clog2(NUM_LINES)-1:0] poll_line_o,
    input logic [DATA_W-1:0]            rd_data_o
);

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_i && wr_data_i[4]) |=> (mask_o == '0 && !spec_mask_o && init_stb_o)); // R1

    AST_START_DROPS_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_i && wr_data_i[4] && !wr_data_i[0]) |=> (!fully_nested_o && !auto_eoi_o)); // R1

    AST_BASE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vec_base_o) |-> $past(wr_en_i && addr_i)); // R2

    AST_MASK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mask_o) |-> $past(wr_en_i)); // R5

    AST_OCW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ocw_stb_o |-> $past(wr_en_i && !addr_i && !wr_data_i[4] && !wr_data_i[3])); // R8

    AST_POLL_NEEDS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        poll_clr_o |-> $past(rd_en_i && win_valid_i)); // R10

    AST_POLL_DATA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        poll_clr_o |-> (rd_data_o == DATA_W'(poll_line_o))); // R10

endmodule

bind irq_regif irq_regif_chk #(.DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr_i         (addr_i),
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .rd_en_i        (rd_en_i),
    .win_valid_i    (win_valid_i),
    .vec_base_o     (vec_base_o),
    .mask_o         (mask_o),
    .fully_nested_o (fully_nested_o),
    .auto_eoi_o     (auto_eoi_o),
    .spec_mask_o    (spec_mask_o),
    .init_stb_o     (init_stb_o),
    .ocw_stb_o      (ocw_stb_o),
    .poll_clr_o     (poll_clr_o),
    .poll_line_o    (poll_line_o),
    .rd_data_o      (rd_data_o)
);

// File: tb/test_irq_regif.sv
`timescale 1ns/1ps
module test_irq_regif;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       rd_en_i = 1'b0;
    logic [7:0] pend_i = 8'h00;
    logic [7:0] insvc_i = 8'h00;
    logic       win_valid_i = 1'b0;
    logic [2:0] win_line_i = '0;
    logic [7:0] vec_base_o, mask_o, ocw_data_o, rd_data_o;
    logic       fully_nested_o, auto_eoi_o, spec_mask_o, init_stb_o, ocw_stb_o, poll_clr_o;
    logic [2:0] poll_line_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_regif i_irq_regif (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .pend_i(pend_i),
        .insvc_i(insvc_i), .win_valid_i(win_valid_i), .win_line_i(win_line_i),
        .vec_base_o(vec_base_o), .mask_o(mask_o), .fully_nested_o(fully_nested_o),
        .auto_eoi_o(auto_eoi_o), .spec_mask_o(spec_mask_o), .init_stb_o(init_stb_o),
        .ocw_stb_o(ocw_stb_o), .ocw_data_o(ocw_data_o), .poll_clr_o(poll_clr_o),
        .poll_line_o(poll_line_o), .rd_data_o(rd_data_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Write one byte; outputs are sampled at the negedge after the edge.
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic a);
        @(negedge clk);
        addr_i = a; rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 mask", mask_o, 0);
        chk("R12 vec_base", vec_base_o, 0);
        chk("R12 flags", {fully_nested_o, auto_eoi_o, spec_mask_o, init_stb_o, ocw_stb_o, poll_clr_o}, 0);
        chk("R12 rd_data", rd_data_o, 0);
    endtask

    task automatic t_init_short;
        wr(1'b1, 8'h3C);
        chk("R5 mask load", mask_o, 8'h3C);
        wr(1'b0, 8'h10);
        chk("R1 init_stb", init_stb_o, 1);
        chk("R1 mask cleared", mask_o, 0);
        @(negedge clk);
        chk("R1 init_stb one cycle", init_stb_o, 0);
        wr(1'b1, 8'hAD);
        chk("R2 vec_base", vec_base_o, 8'hA8);
        wr(1'b1, 8'h04);
        chk("R3 cascade ignored base", vec_base_o, 8'hA8);
        chk("R3 cascade ignored mask", mask_o, 0);
        wr(1'b1, 8'h5A);
        chk("R3 run after cascade", mask_o, 8'h5A);
        chk("R3 modes untouched", {fully_nested_o, auto_eoi_o}, 0);
    endtask

    task automatic t_init_long;
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h47);
        chk("R2 vec_base", vec_base_o, 8'h40);
        wr(1'b1, 8'hFF);
        chk("R3 cascade ignored mask", mask_o, 0);
        wr(1'b1, 8'h12);
        chk("R4 mode word", {fully_nested_o, auto_eoi_o}, 2'b11);
        chk("R4 mode word not mask", mask_o, 0);
        wr(1'b1, 8'h81);
        chk("R4 run after mode word", mask_o, 8'h81);
        wr(1'b0, 8'h11);
        chk("R1 modes kept with fourth-word flag", {fully_nested_o, auto_eoi_o}, 2'b11);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h02);
        chk("R4 auto eoi only", {fully_nested_o, auto_eoi_o}, 2'b01);
        wr(1'b0, 8'h10);
        chk("R1 modes dropped", {fully_nested_o, auto_eoi_o}, 2'b00);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_mode_reads;
        pend_i = 8'h96; insvc_i = 8'h21;
        wr(1'b1, 8'hC3);
        rd(1'b0);
        chk("R9 pending read", rd_data_o, 8'h96);
        rd(1'b1);
        chk("R9 mask read", rd_data_o, 8'hC3);
        wr(1'b0, 8'h0B);
        chk("R8 mode cmd no strobe", ocw_stb_o, 0);
        rd(1'b0);
        chk("R6 in-service read", rd_data_o, 8'h21);
        wr(1'b0, 8'h09);
        rd(1'b0);
        chk("R6 select unchanged", rd_data_o, 8'h21);
        wr(1'b0, 8'h0A);
        rd(1'b0);
        chk("R6 pending selected", rd_data_o, 8'h96);
        wr(1'b0, 8'h68);
        chk("R7 special mask set", spec_mask_o, 1);
        wr(1'b0, 8'h08);
        chk("R7 ignored without enable", spec_mask_o, 1);
        wr(1'b0, 8'h48);
        chk("R7 special mask clear", spec_mask_o, 0);
        wr(1'b0, 8'h68);
        wr(1'b0, 8'h10);
        chk("R1 special mask cleared", spec_mask_o, 0);
        wr(1'b1, 8'h00); wr(1'b1, 8'h00);
    endtask

    task automatic t_ocw;
        wr(1'b0, 8'h67);
        chk("R8 strobe", ocw_stb_o, 1);
        chk("R8 data", ocw_data_o, 8'h67);
        @(negedge clk);
        chk("R8 strobe one cycle", ocw_stb_o, 0);
        wr(1'b1, 8'h20);
        chk("R8 mask write no strobe", ocw_stb_o, 0);
    endtask

    task automatic t_poll;
        pend_i = 8'h33;
        wr(1'b0, 8'h0C);
        win_valid_i = 1'b1; win_line_i = 3'd5;
        rd(1'b1);
        chk("R10 poll data", rd_data_o, 5);
        chk("R10 poll clear", poll_clr_o, 1);
        chk("R10 poll line", poll_line_o, 5);
        rd(1'b0);
        chk("R10 disarmed", rd_data_o, 8'h33);
        chk("R10 clear one shot", poll_clr_o, 0);
        win_valid_i = 1'b0; win_line_i = 3'd2;
        wr(1'b0, 8'h0C);
        rd(1'b0);
        chk("R11 empty poll data", rd_data_o, 7);
        chk("R11 no clear", poll_clr_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_init_short();
        t_init_long();
        t_mode_reads();
        t_ocw();
        t_poll();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule